// File: doc/BRIEF.md
# MDIO Management Master with Register Access

This block lets software reach the management registers of an external Ethernet PHY over the two-wire MDIO interface. It exposes two 32-bit words on a simple register bus. The command word holds the start/busy flag, the operation, the PHY and register addresses and a clock-speed select. The data word carries the 16-bit value that is written out, or that comes back from a read. Software loads the data word first, then writes the command word with the busy flag set. The block runs one Clause 22 frame and clears the busy flag when the frame ends. Software polls that flag before it touches the block again.

The block generates MDC by dividing the system clock. It drives MDIO through an output value and an output enable, and it reads the line back through a separate input. A command write with the busy flag clear, or with an operation that is not recognised, starts no frame. It still emits one full MDC period with MDIO released, because some PHYs need clock edges on MDC before they leave reset.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Writing the command word (bus address 0) with bit 0 set and a valid opcode starts a frame, and bit 0 then reads 1. It reads 0 again exactly 128*HALF+1 system clocks after the accepting write edge, which is one clock after the final falling edge of MDC.
- R2: The opcode sits in command bits 3:2. Value 01 runs a write frame and value 11 runs a read frame. On the wire they are sent as 01 and 10.
- R3: Command bits 16:12 hold the PHY address, bits 11:7 the register address and bits 6:4 the clock select. Every frame sends 32 ones, then 01, then the opcode, then the PHY address and then the register address, each field MSB first.
- R4: A write frame sends turnaround 10 and then the 16 data bits MSB first. The data bits are the data word as it stood on the accepting command write edge. Data-word writes made later in the frame do not change what is sent.
- R5: In a read frame the master releases MDIO (output enable low) for the two turnaround bits and the 16 data bits. Once busy clears, the data word (bus address 1) holds the 16 bits sampled, first bit in bit 15.
- R6: MDIO is never updated in the same clock as a rising MDC edge. The master changes it one system clock after that edge and samples MDIO on the rising edge.
- R7: Each MDC half period lasts HALF = BASE_HALF*(select+1) system clocks, where select is 0 to 7. With the default BASE_HALF of 10 and a 50 MHz system clock, MDC stays at or below 2.5 MHz.
- R8: A command write accepted with bit 0 clear, or with opcode 00 or 10, starts no frame. It produces exactly one MDC high pulse, never enables the MDIO output, and bit 0 stays 0.
- R9: A command write that arrives while a frame or a single pulse is in progress is ignored. The fields read back unchanged and the running frame is unaffected.
- R10: After reset the command and data words read 0, MDC is low and the MDIO output enable is low.
- R11: Reading the data word returns the 16-bit value in bits 15:0 with bits 31:16 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel_data | input | 1 | Word select: 0 command, 1 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
The bench uses a PHY model that counts rising MDC edges and drives read data back after each edge. One corner case is a data-word write made in the middle of a write frame: a design that did not latch its shift data at the start would put the new value on the wire. A second is a command write that lands during a running frame: a block that accepted it would change fields, busy timing or the frame itself. Commands with busy clear or with an invalid opcode must give exactly one MDC pulse with MDIO released; a design that ignored them would give no pulse, and one that treated them as frames would set busy. The busy duration is measured for several clock selects, which exposes an off-by-one divider or an early busy clear. A read that sampled after its own drive change would return data shifted by one bit.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int CSEL_W     = 3;
  localparam int TA_POS     = 46;

  localparam int CMD_GO    = 0;
  localparam int CMD_OP    = 2;
  localparam int CMD_CSEL  = 4;
  localparam int CMD_REGAD = 7;
  localparam int CMD_PHYAD = 12;

  typedef enum logic [1:0] {
    OPC_NOP0  = 2'b00,
    OPC_WRITE = 2'b01,
    OPC_NOP2  = 2'b10,
    OPC_READ  = 2'b11
  } cmd_op_e;

  typedef struct packed {
    logic [4:0]        phy;
    logic [4:0]        regad;
    logic [CSEL_W-1:0] csel;
    cmd_op_e           op;
  } cmd_fields_t;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'b00,
    ENG_FRAME = 2'b01,
    ENG_PULSE = 2'b10
  } eng_state_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int BASE_HALF = 10,
  parameter int CSEL_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CSEL_W-1:0] csel,
  output logic              mdc,
  output logic              rise_tick,
  output logic              fall_tick
);
  localparam int MAX_HALF = BASE_HALF * (1 << CSEL_W);
  localparam int CNT_W    = $clog2(MAX_HALF + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             mdc_q, mdc_d, at_lim;

  assign lim    = CNT_W'(BASE_HALF * (32'(csel) + 1) - 1);
  assign at_lim = (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (at_lim) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = run & at_lim & ~mdc_q;
  assign fall_tick = run & at_lim & mdc_q;

  // MDC only toggles when a half period has fully elapsed
  assert_mdc_half_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_q != $past(mdc_q)) |-> ($past(at_lim) || !$past(run)));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_frame,
  input  logic        start_pulse,
  input  cmd_fields_t start_fld,
  input  logic [15:0] tx_data,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        run,
  output logic        active,
  output logic        done,
  output logic [15:0] rx_data,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int BC_W = $clog2(FRAME_BITS);

  eng_state_e            state_q, state_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [15:0]           rx_q, rx_d;
  logic [BC_W-1:0]       bit_q, bit_d;
  logic                  last_q, last_d, rd_q, rd_d, done_q, done_d;
  logic                  out_q, out_d, oe_q, oe_d;
  logic                  is_rd;

  assign is_rd = (start_fld.op == OPC_READ);

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    rx_d    = rx_q;
    bit_d   = bit_q;
    last_d  = last_q;
    rd_d    = rd_q;
    done_d  = 1'b0;
    unique case (state_q)
      ENG_IDLE: begin
        if (start_frame) begin
          state_d = ENG_FRAME;
          sh_d    = {32'hFFFF_FFFF, 2'b01, (is_rd ? 2'b10 : 2'b01),
                     start_fld.phy, start_fld.regad, 2'b10,
                     (is_rd ? 16'hFFFF : tx_data)};
          bit_d   = '0;
          last_d  = 1'b0;
          rd_d    = is_rd;
        end else if (start_pulse) begin
          state_d = ENG_PULSE;
        end
      end
      ENG_FRAME: begin
        if (rise_tick) begin
          sh_d = {sh_q[FRAME_BITS-2:0], 1'b0};
          rx_d = {rx_q[14:0], mdio_i};
          if (bit_q == BC_W'(FRAME_BITS - 1)) last_d = 1'b1;
          else                                bit_d  = bit_q + 1'b1;
        end
        if (fall_tick && last_q) begin
          state_d = ENG_IDLE;
          done_d  = 1'b1;
        end
      end
      ENG_PULSE: begin
        if (fall_tick) state_d = ENG_IDLE;
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  // Output register follows the shift register one clock late, so that the
  // line never moves in the clock where MDC rises.
  always_comb begin
    out_d = sh_q[FRAME_BITS-1];
    oe_d  = (state_q == ENG_FRAME) && !last_q &&
            !(rd_q && (bit_q >= BC_W'(TA_POS)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      sh_q    <= '0;
      rx_q    <= '0;
      bit_q   <= '0;
      last_q  <= 1'b0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
      out_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      rx_q    <= rx_d;
      bit_q   <= bit_d;
      last_q  <= last_d;
      rd_q    <= rd_d;
      done_q  <= done_d;
      out_q   <= out_d;
      oe_q    <= oe_d;
    end
  end

  assign run     = (state_q != ENG_IDLE);
  assign active  = (state_q != ENG_IDLE);
  assign done    = done_q;
  assign rx_data = rx_q;
  assign mdio_o  = out_q;
  assign mdio_oe = oe_q;

  // A settled idle engine never drives the line
  assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_IDLE && $past(state_q == ENG_IDLE)) |-> !oe_q);
  // The single pulse never drives the line
  assert_pulse_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_PULSE && $past(state_q == ENG_PULSE)) |-> !oe_q);
  // Completion only follows the last bit
  assert_done_after_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(last_q));
endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel_data,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        eng_active,
  input  logic        eng_done,
  input  logic [15:0] rx_data,
  output logic        start_frame,
  output logic        start_pulse,
  output cmd_fields_t wr_fld,
  output cmd_fields_t fld,
  output logic [15:0] tx_data
);
  cmd_fields_t fld_q;
  logic [15:0] data_q, data_d;
  logic        busy_q, busy_d;
  logic        cmd_hit, accept, go, fld_en, data_en;

  assign wr_fld.phy   = reg_wdata[CMD_PHYAD +: 5];
  assign wr_fld.regad = reg_wdata[CMD_REGAD +: 5];
  assign wr_fld.csel  = reg_wdata[CMD_CSEL +: CSEL_W];
  assign wr_fld.op    = cmd_op_e'(reg_wdata[CMD_OP +: 2]);

  assign cmd_hit = reg_wr & ~reg_sel_data;
  assign accept  = cmd_hit & ~busy_q & ~eng_active;
  assign go      = accept & reg_wdata[CMD_GO] &
                   ((wr_fld.op == OPC_WRITE) || (wr_fld.op == OPC_READ));
  assign fld_en  = accept;

  assign start_frame = go;
  assign start_pulse = accept & ~go;

  always_comb begin
    busy_d  = busy_q;
    if (go)       busy_d = 1'b1;
    if (eng_done) busy_d = 1'b0;
    data_en = 1'b0;
    data_d  = data_q;
    if (reg_wr && reg_sel_data) begin
      data_en = 1'b1;
      data_d  = reg_wdata[15:0];
    end
    if (eng_done && fld_q.op == OPC_READ) begin
      data_en = 1'b1;
      data_d  = rx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q  <= '0;
      data_q <= '0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      if (fld_en)  fld_q  <= wr_fld;
      if (data_en) data_q <= data_d;
    end
  end

  always_comb begin
    if (reg_sel_data) reg_rdata = {16'h0000, data_q};
    else              reg_rdata = {15'h0000, fld_q.phy, fld_q.regad, fld_q.csel,
                                   fld_q.op, 1'b0, busy_q};
  end

  assign fld     = fld_q;
  assign tx_data = data_q;

  // A command that arrives mid-operation leaves the fields untouched
  assert_ignore_busy_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && (busy_q || eng_active)) |=> $stable(fld_q));
  // Busy only drops on engine completion
  assert_busy_clears_on_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(eng_done));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int BASE_HALF = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel_data,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  logic        start_frame, start_pulse, eng_active, eng_done, run;
  logic        rise_tick, fall_tick;
  logic [15:0] rx_data, tx_data;
  cmd_fields_t wr_fld, fld;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mdio_csr u_csr (
    .clk(clk), .rst_n(rst_int_n), .reg_wr(reg_wr), .reg_sel_data(reg_sel_data),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_active(eng_active),
    .eng_done(eng_done), .rx_data(rx_data), .start_frame(start_frame),
    .start_pulse(start_pulse), .wr_fld(wr_fld), .fld(fld), .tx_data(tx_data)
  );

  mdio_clkgen #(.BASE_HALF(BASE_HALF), .CSEL_W(CSEL_W)) u_clk (
    .clk(clk), .rst_n(rst_int_n), .run(run), .csel(fld.csel), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_int_n), .start_frame(start_frame),
    .start_pulse(start_pulse), .start_fld(wr_fld), .tx_data(tx_data),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i), .run(run),
    .active(eng_active), .done(eng_done), .rx_data(rx_data), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe)
  );

  // The line value holds still across every rising MDC edge
  assert_mdio_stable_at_rise_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

// File: tb/sim_mdio_mgmt_master.sv
module sim_mdio_mgmt_master;
  localparam int BASE_HALF = 10;

  logic        clk, rst_n, reg_wr, reg_sel_data;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mdc_w, mdio_o_w, mdio_oe_w;
  logic        phy_oe, phy_val;
  wire         mdio_line = mdio_oe_w ? mdio_o_w : (phy_oe ? phy_val : 1'b1);

  int n_chk, n_fail, cyc, rise_cnt, base, contention, oe_cycles, r6_bad;
  logic [63:0] phy_frame;
  logic [15:0] phy_rd_val;
  bit          phy_read_mode;
  realtime     t_rise, t_mdio;

  mdio_mgmt_master #(.BASE_HALF(BASE_HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel_data(reg_sel_data),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc_w),
    .mdio_o(mdio_o_w), .mdio_oe(mdio_oe_w), .mdio_i(mdio_line)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
      $finish;
    end
  end

  always @(posedge clk) begin
    if (mdio_oe_w && phy_oe) contention <= contention + 1;
    if (mdio_oe_w)           oe_cycles  <= oe_cycles + 1;
  end

  // R6 monitor: line and rising MDC never in the same time step
  always @(posedge mdc_w) begin
    t_rise = $realtime;
    if (t_mdio == t_rise) r6_bad++;
  end
  always @(mdio_o_w) begin
    t_mdio = $realtime;
    if (t_rise == t_mdio) r6_bad++;
  end

  // PHY model: samples at rising MDC, drives the next read bit after it
  always @(posedge mdc_w) begin
    int idx;
    idx = rise_cnt - base;
    if (idx >= 0 && idx < 64) phy_frame[63 - idx] <= mdio_line;
    rise_cnt <= rise_cnt + 1;
    phy_oe   <= 1'b0;
    if (phy_read_mode && idx + 1 >= 47 && idx + 1 <= 63) begin
      phy_oe  <= 1'b1;
      phy_val <= (idx + 1 == 47) ? 1'b0 : phy_rd_val[63 - (idx + 1)];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(bit rd, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, 2'b10, d};
  endfunction

  function automatic logic [31:0] cmd_word(bit go, logic [1:0] op, logic [4:0] p, logic [4:0] r, logic [2:0] cs);
    return {15'h0, p, r, cs, op, 1'b0, go};
  endfunction

  task automatic bus_write(input bit sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel_data = sel; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_sel_data = 1'b0;
  endtask

  task automatic bus_read(input bit sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel_data = sel;
    #1 d = reg_rdata;
    reg_sel_data = 1'b0;
  endtask

  // Counts clocks from the accepting edge until busy reads 0
  task automatic wait_idle(output int n);
    n = 0;
    reg_sel_data = 1'b0;
    forever begin
      #1;
      if (!reg_rdata[0]) break;
      @(posedge clk); n++;
      @(negedge clk);
    end
  endtask

  task automatic run_txn(input bit rd, input logic [4:0] p, input logic [4:0] r,
                         input logic [2:0] cs, input logic [15:0] d);
    int n; logic [31:0] v; logic [63:0] ef;
    base = rise_cnt; phy_read_mode = rd; phy_rd_val = d;
    if (!rd) bus_write(1'b1, {16'h0, d});
    @(negedge clk);
    reg_wr = 1'b1; reg_sel_data = 1'b0; reg_wdata = cmd_word(1'b1, rd ? 2'b11 : 2'b01, p, r, cs);
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
    wait_idle(n);
    chk(n == 128 * BASE_HALF * (cs + 1) + 1, "R1/R7 busy duration", 64'(n), 64'(128 * BASE_HALF * (cs + 1) + 1));
    ef = exp_frame(rd, p, r, d);
    chk(phy_frame[63:18] == ef[63:18], "R2/R3 frame header", {18'h0, phy_frame[63:18]}, {18'h0, ef[63:18]});
    if (!rd) chk(phy_frame[17:0] == ef[17:0], "R4 turnaround and data", 64'(phy_frame[17:0]), 64'(ef[17:0]));
    else begin
      bus_read(1'b1, v);
      chk(v == {16'h0, d}, "R5/R11 read data word", 64'(v), 64'({16'h0, d}));
    end
  endtask

  initial begin
    logic [31:0] v; int n, r0, o0;
    n_chk = 0; n_fail = 0; cyc = 0; rise_cnt = 0; base = 0; contention = 0; oe_cycles = 0;
    r6_bad = 0; t_rise = -1.0; t_mdio = -2.0; phy_oe = 1'b0; phy_val = 1'b1; phy_read_mode = 1'b0;
    phy_rd_val = '0; phy_frame = '0;
    reg_wr = 1'b0; reg_sel_data = 1'b0; reg_wdata = '0;
    void'($urandom(32'h0000_1D05));
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R10 reset state
    bus_read(1'b0, v); chk(v == 32'h0, "R10 command word after reset", 64'(v), 64'h0);
    bus_read(1'b1, v); chk(v == 32'h0, "R10 data word after reset", 64'(v), 64'h0);
    chk(mdc_w == 1'b0 && mdio_oe_w == 1'b0, "R10 mdc and oe low", {mdc_w, mdio_oe_w}, 2'b00);

    // R11 data word readback
    bus_write(1'b1, 32'hDEAD_BEEF);
    bus_read(1'b1, v); chk(v == 32'h0000_BEEF, "R11 data word upper bits zero", 64'(v), 64'h0000_BEEF);

    // Directed frames: extreme field values, several clock selects
    run_txn(1'b0, 5'h1F, 5'h00, 3'd0, 16'h8001);
    run_txn(1'b1, 5'h00, 5'h1F, 3'd1, 16'hC35A);
    run_txn(1'b0, 5'h15, 5'h0A, 3'd2, 16'h0000);
    run_txn(1'b1, 5'h0A, 5'h15, 3'd0, 16'hFFFF);

    // R4 and R9: data and command writes during a running write frame
    base = rise_cnt; phy_read_mode = 1'b0;
    bus_write(1'b1, 32'h0000_A5C3);
    bus_write(1'b0, cmd_word(1'b1, 2'b01, 5'h03, 5'h09, 3'd0));
    repeat (100) @(posedge clk);
    bus_write(1'b1, 32'h0000_1111);
    bus_write(1'b0, cmd_word(1'b1, 2'b11, 5'h1C, 5'h11, 3'd3));
    wait_idle(n);
    chk(phy_frame == exp_frame(1'b0, 5'h03, 5'h09, 16'hA5C3), "R4/R9 frame unaffected",
        phy_frame, exp_frame(1'b0, 5'h03, 5'h09, 16'hA5C3));
    bus_read(1'b0, v);
    chk(v == cmd_word(1'b0, 2'b01, 5'h03, 5'h09, 3'd0), "R9 fields kept", 64'(v),
        64'(cmd_word(1'b0, 2'b01, 5'h03, 5'h09, 3'd0)));
    bus_read(1'b1, v); chk(v == 32'h0000_1111, "R4 later data write stored", 64'(v), 64'h1111);

    // R8 dummy pulse: busy clear, then invalid opcode with busy set
    for (int k = 0; k < 2; k++) begin
      r0 = rise_cnt; o0 = oe_cycles;
      bus_write(1'b0, (k == 0) ? cmd_word(1'b0, 2'b11, 5'h01, 5'h01, 3'd0)
                               : cmd_word(1'b1, 2'b10, 5'h01, 5'h01, 3'd0));
      bus_read(1'b0, v); chk(v[0] == 1'b0, "R8 busy stays clear", 64'(v[0]), 64'h0);
      repeat (4 * BASE_HALF) @(posedge clk);
      @(negedge clk);
      chk(rise_cnt - r0 == 1, "R8 one MDC pulse", 64'(rise_cnt - r0), 64'h1);
      chk(oe_cycles == o0, "R8 MDIO not driven", 64'(oe_cycles - o0), 64'h0);
    end

    // Random frames
    for (int k = 0; k < 8; k++) begin
      run_txn(1'($urandom % 2), 5'($urandom), 5'($urandom), 3'($urandom % 2), 16'($urandom));
    end

    chk(contention == 0, "R5 master released during read turnaround/data", 64'(contention), 64'h0);
    chk(r6_bad == 0, "R6 MDIO moves apart from rising MDC", 64'(r6_bad), 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule